// File: doc/BRIEF.md
# DSP Register Shifter with Overflow Flags

This block is the shift stage of a fixed-point DSP datapath. Each cycle it can take one 32-bit operand, a shift count and a form selector. It produces a shifted result and an overflow indication, both held in output registers. Three forms are supported:

- a single 16-bit half-word shift, where the source half and the destination half are selectable and the other destination half is kept;
- a paired shift of the two 16-bit halves of one word by a common count;
- a full 32-bit word shift.

A positive count shifts left. A zero or negative count shifts right arithmetically. An optional saturating mode clamps a left shift whose sign bit flipped. A sticky overflow bit collects every overflow until it is cleared explicitly.

The count arrives in one of two encodings. In the register encoding the count field is a signed value. In the immediate encoding, used for the half-word and paired forms, the count field is a small unsigned number: values above the half width stand for left shifts, and the rest stand for right shifts. A new request is accepted whenever `in_valid` is high. Its result appears on the outputs one clock later.

Top module: `dsp_shifter`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first accepted request, `result`, `v_flag`, `vs_flag` and `res_valid` are all zero.
- R2: `mode` selects the form: 2'b00 half-word, 2'b01 paired halves, 2'b10 and 2'b11 full word. In the register encoding (`cnt_imm`=0) the 6-bit `cnt` is two's complement, giving -32..+31, and a positive value shifts left by that many places.
- R3: A register count of zero or less shifts right arithmetically by its magnitude. A shift of the lane width or more fills the lane with its sign bit. A right shift or a zero count never raises `v_flag`. A zero count passes the operand through unchanged.
- R4: Without saturation (`sat`=0), a left shift drops the bits that leave the lane, and a shift of the lane width or more gives zero. `v_flag` is raised when the lane's most significant bit (bit 15 of a half, bit 31 of a word) differs before and after the shift.
- R5: With `sat`=1, a left shift that flips the most significant bit gives the largest positive value (0x7FFF or 0x7FFFFFFF) for a non-negative operand. For a negative operand it gives the most negative value (0x8000 or 0x80000000). `v_flag` is raised in that case as well.
- R6: In the paired form each half is shifted on its own by the same count. The results are packed with the upper half's result in bits 31:16. `v_flag` is the OR of the two halves' overflow.
- R7: With `cnt_imm`=1 in the half-word or paired form, only `cnt[4:0]` is used, as an unsigned value c. If c > 16, the lane shifts left by 16 - c[3:0]. Otherwise it shifts right arithmetically by c. The word form ignores `cnt_imm` and always uses the register encoding.
- R8: In the half-word form, `src_hi`=1 takes the operand from bits 31:16, and otherwise from bits 15:0. `dst_hi`=1 places the result in bits 31:16, and otherwise in bits 15:0. The other half of `result` is copied from `dst_prev`.
- R9: `vs_flag` is set in every cycle in which `v_flag` is loaded with 1, and is otherwise held. `vs_clr` clears it. A clear in the same cycle as an accepted overflowing request leaves it set.
- R10: An accepted request updates `result` and `v_flag` on the next rising edge. `res_valid` is a registered copy of `in_valid`. Without `in_valid`, `result` and `v_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept a shift request this cycle |
| mode | input | 2 | Form: 00 half-word, 01 paired halves, 1x word |
| cnt_imm | input | 1 | Count uses the immediate encoding (half-word and paired forms) |
| sat | input | 1 | Saturate left shifts that flip the sign bit |
| src_hi | input | 1 | Half-word form: source is the upper half of `operand` |
| dst_hi | input | 1 | Half-word form: result goes to the upper half |
| cnt | input | 6 | Shift count |
| operand | input | 32 | Value to shift |
| dst_prev | input | 32 | Previous destination value, kept in the unwritten half |
| vs_clr | input | 1 | Clear the sticky overflow bit |
| result | output | 32 | Registered shift result |
| v_flag | output | 1 | Overflow from the last accepted request |
| vs_flag | output | 1 | Sticky overflow |
| res_valid | output | 1 | `result` and `v_flag` were loaded on the last edge |

## Verification
The vector table runs each form through several input patterns:

- positive, negative and zero register counts, which separate the left path, the right path and the pass-through;
- the extreme counts -32 and +16 on a 16-bit lane, which check the sign fill and the zero fill when the shift reaches the lane width;
- operands whose top bit flips, run once without and once with saturation, which separate truncation from clamping and check the clamp direction for both operand signs;
- paired inputs where only one half flips, which show that the overflow is an OR and that the halves do not mix;
- immediate counts 3, 16, 17 and 20, which sit on both sides of the re-encoding threshold.

Directed steps then exercise the sticky bit against clears, including a clear in the same cycle as an overflow, and check that outputs hold while idle.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_HALF     = 2'b00,
        SHF_PAIR     = 2'b01,
        SHF_WORD     = 2'b10,
        SHF_WORD_ALT = 2'b11
    } shf_form_e;

    typedef struct packed {
        logic       left;
        logic [5:0] amt;
    } shf_dir_t;

endpackage

// File: rtl/shf_count_dec.sv
// Turns a count field into a direction and an unsigned amount.
module shf_count_dec #(
    parameter int CW = 6,
    parameter int HW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic          imm,
    output logic          left,
    output logic [CW-1:0] amt
);
    localparam int IW = $clog2(HW) + 1;
    localparam logic [IW-1:0] THR  = IW'(HW);
    localparam logic [CW-1:0] HWC  = CW'(HW);

    logic [IW-1:0] imm_val;

    always_comb begin
        imm_val = cnt[IW-1:0];
        if (imm) begin
            if (imm_val > THR) begin
                left = 1'b1;
                amt  = HWC - CW'(imm_val[IW-2:0]);
            end else begin
                left = 1'b0;
                amt  = CW'(imm_val);
            end
        end else begin
            left = !cnt[CW-1] && (cnt != '0);
            amt  = left ? cnt : (CW'(0) - cnt);
        end
    end
endmodule

// File: rtl/shf_lane.sv
// One lane: arithmetic right, or left with sign-change overflow and optional clamp.
module shf_lane #(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic [W-1:0]  a,
    input  logic          left,
    input  logic [AW-1:0] amt,
    input  logic          sat,
    output logic [W-1:0]  y,
    output logic          ovf
);
    localparam logic [AW-1:0] LIM = AW'(W);
    localparam logic [W-1:0]  POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  NEG_MAX = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] shl;
    logic [W-1:0] shr;

    always_comb begin
        if (amt >= LIM) begin
            shl = '0;
            shr = {W{a[W-1]}};
        end else begin
            shl = a << amt;
            shr = W'($signed(a) >>> amt);
        end
        ovf = left && (shl[W-1] != a[W-1]);
        if (!left)
            y = shr;
        else if (ovf && sat)
            y = a[W-1] ? NEG_MAX : POS_MAX;
        else
            y = shl;
    end
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter #(
    parameter int DW = 32,
    parameter int CW = $clog2(DW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    mode,
    input  logic          cnt_imm,
    input  logic          sat,
    input  logic          src_hi,
    input  logic          dst_hi,
    input  logic [CW-1:0] cnt,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] dst_prev,
    input  logic          vs_clr,
    output logic [DW-1:0] result,
    output logic          v_flag,
    output logic          vs_flag,
    output logic          res_valid
);
    import shf_pkg::*;

    localparam int HW    = DW / 2;
    localparam int NLANE = 2;

    shf_form_e form;
    logic          h_left, w_left;
    logic [CW-1:0] h_amt, w_amt;
    logic [HW-1:0] lane_in  [NLANE];
    logic [HW-1:0] lane_out [NLANE];
    logic [NLANE-1:0] lane_ovf;
    logic [DW-1:0] word_out;
    logic          word_ovf;
    logic [DW-1:0] nxt_result;
    logic          nxt_v;

    assign form = shf_form_e'(mode);

    shf_count_dec #(.CW(CW), .HW(HW)) u_hdec (
        .cnt (cnt),
        .imm (cnt_imm),
        .left(h_left),
        .amt (h_amt)
    );

    shf_count_dec #(.CW(CW), .HW(HW)) u_wdec (
        .cnt (cnt),
        .imm (1'b0),
        .left(w_left),
        .amt (w_amt)
    );

    assign lane_in[0] = (form == SHF_HALF && src_hi) ? operand[DW-1:HW] : operand[HW-1:0];
    assign lane_in[1] = operand[DW-1:HW];

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        shf_lane #(.W(HW), .AW(CW)) u_lane (
            .a   (lane_in[i]),
            .left(h_left),
            .amt (h_amt),
            .sat (sat),
            .y   (lane_out[i]),
            .ovf (lane_ovf[i])
        );
    end

    shf_lane #(.W(DW), .AW(CW)) u_word (
        .a   (operand),
        .left(w_left),
        .amt (w_amt),
        .sat (sat),
        .y   (word_out),
        .ovf (word_ovf)
    );

    always_comb begin
        unique case (form)
            SHF_HALF: begin
                nxt_result = dst_hi ? {lane_out[0], dst_prev[HW-1:0]}
                                    : {dst_prev[DW-1:HW], lane_out[0]};
                nxt_v      = lane_ovf[0];
            end
            SHF_PAIR: begin
                nxt_result = {lane_out[1], lane_out[0]};
                nxt_v      = |lane_ovf;
            end
            SHF_WORD, SHF_WORD_ALT: begin
                nxt_result = word_out;
                nxt_v      = word_ovf;
            end
            default: begin
                nxt_result = word_out;
                nxt_v      = word_ovf;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            v_flag    <= 1'b0;
            vs_flag   <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_result;
                v_flag <= nxt_v;
            end
            if (in_valid && nxt_v)
                vs_flag <= 1'b1;
            else if (vs_clr)
                vs_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dsp_shifter_chk.sv
module dsp_shifter_chk #(
    parameter int DW = 32,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    mode,
    input logic          cnt_imm,
    input logic          dst_hi,
    input logic [CW-1:0] cnt,
    input logic [DW-1:0] operand,
    input logic [DW-1:0] dst_prev,
    input logic          vs_clr,
    input logic [DW-1:0] result,
    input logic          v_flag,
    input logic          vs_flag,
    input logic          res_valid
);
    localparam int HW = DW / 2;

    p_zero_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && cnt == '0) |=> (result == $past(operand) && !v_flag));

    p_right_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!cnt_imm || mode[1]) && (cnt[CW-1] || cnt == '0)) |=> !v_flag);

    p_keep_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && dst_hi) |=> result[HW-1:0] == $past(dst_prev[HW-1:0]));

    p_keep_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && !dst_hi) |=> result[DW-1:HW] == $past(dst_prev[DW-1:HW]));

    p_v_implies_vs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        v_flag && $past(in_valid) |-> vs_flag);

    p_vs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_flag && !vs_clr) |=> vs_flag);

    p_vs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_clr && !in_valid) |=> !vs_flag);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(v_flag) && !res_valid));

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
endmodule

bind dsp_shifter dsp_shifter_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (mode),
    .cnt_imm  (cnt_imm),
    .dst_hi   (dst_hi),
    .cnt      (cnt),
    .operand  (operand),
    .dst_prev (dst_prev),
    .vs_clr   (vs_clr),
    .result   (result),
    .v_flag   (v_flag),
    .vs_flag  (vs_flag),
    .res_valid(res_valid)
);

// File: tb/dsp_shifter_bench.sv
`timescale 1ns/100ps
module dsp_shifter_bench;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  md;
        logic        imm;
        logic        sat;
        logic        shi;
        logic        dhi;
        logic [5:0]  cnt;
        logic [31:0] op;
        logic [31:0] prev;
        logic [31:0] exp;
        logic        ev;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'h04, 32'h0000_1234, 32'h0,           32'h0001_2340, 1'b0}, // R2 word left
        '{4'd3,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3C, 32'h8000_0010, 32'h0,           32'hF800_0001, 1'b0}, // R3 word right
        '{4'd3,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 32'hDEAD_BEEF, 32'h0,           32'hDEAD_BEEF, 1'b0}, // R3 zero
        '{4'd4,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'h01, 32'h4000_0000, 32'h0,           32'h8000_0000, 1'b1}, // R4 flip
        '{4'd5,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 6'h01, 32'h4000_0000, 32'h0,           32'h7FFF_FFFF, 1'b1}, // R5 clamp pos
        '{4'd3,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'h20, 32'h8000_0000, 32'h0,           32'hFFFF_FFFF, 1'b0}, // R3 -32
        '{4'd5,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 6'h04, 32'h8000_0001, 32'h0,           32'h8000_0000, 1'b1}, // R5 clamp neg
        '{4'd8,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h03, 32'hAAAA_0011, 32'h1234_5678,   32'h1234_0088, 1'b0}, // R8 low
        '{4'd8,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 6'h3E, 32'h8004_0000, 32'h1234_5678,   32'hE001_5678, 1'b0}, // R8 high
        '{4'd4,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h01, 32'h0000_4000, 32'h0,           32'h0000_8000, 1'b1}, // R4 half flip
        '{4'd5,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 6'h01, 32'h0000_4000, 32'h0,           32'h0000_7FFF, 1'b1}, // R5 half clamp
        '{4'd6,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h01, 32'h4000_0001, 32'h0,           32'h8000_0002, 1'b1}, // R6 one half flips
        '{4'd6,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, 32'h8000_0002, 32'h0,           32'hC000_0001, 1'b0}, // R6 right
        '{4'd6,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 6'h02, 32'h0001_C000, 32'h0,           32'h0004_8000, 1'b1}, // R6 sat low half
        '{4'd7,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h14, 32'h0000_0003, 32'h0,           32'h0000_3000, 1'b0}, // R7 imm 20
        '{4'd7,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h10, 32'h0000_8000, 32'h0,           32'h0000_FFFF, 1'b0}, // R7 imm 16
        '{4'd7,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h11, 32'h0001_0002, 32'h0,           32'h8000_0000, 1'b1}, // R7 imm 17
        '{4'd7,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h23, 32'h8000_0010, 32'h0,           32'hF000_0002, 1'b0}, // R7 imm 3
        '{4'd7,  2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 6'h04, 32'h0000_0001, 32'h0,           32'h0000_0010, 1'b0}, // R7 word ignores imm
        '{4'd4,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h10, 32'h0000_00FF, 32'h0,           32'h0000_0000, 1'b0}  // R4 +16 zero fill
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic        cnt_imm = 1'b0;
    logic        sat = 1'b0;
    logic        src_hi = 1'b0;
    logic        dst_hi = 1'b0;
    logic [5:0]  cnt = '0;
    logic [31:0] operand = '0;
    logic [31:0] dst_prev = '0;
    logic        vs_clr = 1'b0;
    logic [31:0] result;
    logic        v_flag;
    logic        vs_flag;
    logic        res_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dsp_shifter u_dsp_shifter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .cnt_imm(cnt_imm), .sat(sat), .src_hi(src_hi), .dst_hi(dst_hi),
        .cnt(cnt), .operand(operand), .dst_prev(dst_prev), .vs_clr(vs_clr),
        .result(result), .v_flag(v_flag), .vs_flag(vs_flag), .res_valid(res_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t t, input logic clr);
        @(negedge clk);
        in_valid = 1'b1;
        mode = t.md; cnt_imm = t.imm; sat = t.sat;
        src_hi = t.shi; dst_hi = t.dhi; cnt = t.cnt;
        operand = t.op; dst_prev = t.prev; vs_clr = clr;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        vs_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        #12;
        check("R1 result in reset", result, 32'h0);
        check("R1 flags in reset", {29'h0, v_flag, vs_flag, res_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {result[30:0] | {28'h0, v_flag, vs_flag, res_valid}}, 31'h0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i], 1'b0);
            check($sformatf("R%0d vec%0d result", TBL[i].req, i), result, TBL[i].exp);
            check($sformatf("R%0d vec%0d v_flag", TBL[i].req, i), {31'h0, v_flag}, {31'h0, TBL[i].ev});
            check($sformatf("R10 vec%0d res_valid", i), {31'h0, res_valid}, 32'h1);
        end

        // R10 idle hold with clear; R9 clear
        @(negedge clk);
        vs_clr = 1'b1;
        @(posedge clk);
        #1;
        vs_clr = 1'b0;
        check("R10 idle result hold", result, TBL[NV-1].exp);
        check("R10 idle res_valid", {31'h0, res_valid}, 32'h0);
        check("R9 vs cleared", {31'h0, vs_flag}, 32'h0);

        apply(TBL[0], 1'b0);
        check("R9 no overflow keeps vs low", {31'h0, vs_flag}, 32'h0);
        apply(TBL[3], 1'b0);
        check("R9 overflow sets vs", {30'h0, v_flag, vs_flag}, 32'h3);
        apply(TBL[0], 1'b0);
        check("R9 vs sticky", {30'h0, v_flag, vs_flag}, 32'h1);
        apply(TBL[3], 1'b1);
        check("R9 set wins over clear", {31'h0, vs_flag}, 32'h1);
        apply(TBL[0], 1'b1);
        check("R9 clear with request", {31'h0, vs_flag}, 32'h0);

        finish_run();
    end
endmodule